// File: doc/BRIEF.md
# Floating-Point Serial Audio Receiver

This block sits behind the serial audio output of an FM synthesis device. That device does not send plain PCM. Each sample travels as a 16-bit word in a small floating-point format: an offset-binary mantissa and a shift count stored inverted. Two channel-select strobes mark whether the word being shifted belongs to the left or the right channel. The receiver brings the serial bit clock, the data line and both strobes into the system clock domain. It collects the bits of each word and turns the finished word into a 16-bit two's-complement sample for the channel whose strobe has just ended.

Each channel has its own sample register and a one-cycle valid pulse. A downstream mixer or modulator reads the sample when the pulse is high. The sample register keeps its value until the next word for that channel arrives. A word whose exponent field is all zeros is reserved and produces silence.

Top module: `fpa_serial_rx`

## Requirements
- R1: After reset, both samples are 0 and both valid outputs are low.
- R2: A data bit is taken on each rising edge of the serial bit clock, least significant bit first. Within a word, bit positions 3..12 are mantissa bits D0..D9 and positions 13..15 are exponent bits E0..E2.
- R3: The mantissa is offset binary. D9 is the inverted sign, and the signed mantissa value is m = mantissa - 512. The odd amplitude term is 2m+1, so it is never zero.
- R4: For a nonzero exponent e, the shift count is N = 7 - e (the bitwise inverse of the field). The sample is floor((2m+1)*32 / 2^N). This gives 32736 for mantissa 0x3FF with e=7 and -32736 for mantissa 0x000 with e=7.
- R5: A word with exponent 000 produces a sample of 0, and the valid pulse is still raised.
- R6: A falling edge of the left strobe updates only the left sample. A falling edge of the right strobe updates only the right sample. Each update raises that channel's valid output for exactly one clock.
- R7: Between updates, each channel holds its last sample, whatever the other channel, the bit clock or the data line do.
- R8: A level seen on any serial input at rising clock edge k takes effect at edge k+2. A strobe fall first seen at edge k therefore shows on the sample and valid outputs after edge k+2.
- R9: Word bits 0..2 have no effect on the decoded sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data, valid around rising ser_clk |
| sel_left | input | 1 | Left channel strobe, high while the left word shifts |
| sel_right | input | 1 | Right channel strobe, high while the right word shifts |
| left_sample | output | 16 | Left linear sample, two's complement |
| left_valid | output | 1 | One-cycle pulse on a left update |
| right_sample | output | 16 | Right linear sample, two's complement |
| right_valid | output | 1 | One-cycle pulse on a right update |

## Verification
Every serial input passes two synchronizer flops and one edge-detect flop. A strobe fall seen at the pins at clock edge k therefore changes the sample and valid outputs at edge k+2. A bit-clock rise seen at edge k shifts the data level captured at that same edge in at edge k+2. The bench keeps a history of pin levels taken at each rising edge and applies each event two edges later in its model. It compares both samples and both valid outputs against that model in the middle of every clock period, so an update one cycle early or one cycle late is reported. Directed checks after each word then compare the held sample with a value computed by integer floor division from R4.

// File: rtl/fpa_rx_pkg.sv
package fpa_rx_pkg;
  localparam int WORD_W    = 16;
  localparam int DC_W      = 3;
  localparam int MANT_W    = 10;
  localparam int EXP_W     = 3;
  localparam int OUT_W     = 16;
  localparam int PRE_SHIFT = OUT_W - MANT_W - 1;
  localparam int PAY_W     = MANT_W + EXP_W;
  localparam int EXP_LSB   = MANT_W;

  // Turn mantissa/exponent into a linear sample; exponent 0 is reserved
  function automatic logic signed [OUT_W-1:0] fp_to_lin(
    input logic [MANT_W-1:0] mant,
    input logic [EXP_W-1:0]  expo
  );
    logic signed [MANT_W:0]  odd_term;
    logic signed [OUT_W-1:0] widened;
    logic [EXP_W-1:0]        shamt;
    odd_term = {~mant[MANT_W-1], mant[MANT_W-2:0], 1'b1};
    widened  = {{(OUT_W-MANT_W-1){odd_term[MANT_W]}}, odd_term};
    widened  = widened <<< PRE_SHIFT;
    shamt    = ~expo;
    if (expo == '0) fp_to_lin = '0;
    else            fp_to_lin = widened >>> shamt;
  endfunction
endpackage

// File: rtl/fpa_rx_sync.sv
module fpa_rx_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[b];
        stable_q <= meta_q;
      end
    end
    assign sync_out[b] = stable_q;
  end
endmodule

// File: rtl/fpa_rx_shifter.sv
module fpa_rx_shifter
  import fpa_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             bit_in,
  output logic [PAY_W-1:0] payload
);
  // Only the last PAY_W bits are kept; the leading don't-care bits fall off
  logic [PAY_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (bit_rise) shreg_q <= {bit_in, shreg_q[PAY_W-1:1]};
  end

  assign payload = shreg_q;

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> shreg_q[PAY_W-1] == $past(bit_in));
  assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_rise |=> $stable(shreg_q));
endmodule

// File: rtl/fpa_rx_lane.sv
module fpa_rx_lane
  import fpa_rx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe_fall,
  input  logic [PAY_W-1:0]        payload,
  output logic signed [OUT_W-1:0] sample,
  output logic                    valid
);
  logic                    latch_evt;
  logic [EXP_W-1:0]        word_exp;
  logic [MANT_W-1:0]       word_mant;
  logic signed [OUT_W-1:0] sample_q;
  logic                    valid_q;

  assign latch_evt = strobe_fall;
  assign word_mant = payload[MANT_W-1:0];
  assign word_exp  = payload[EXP_LSB +: EXP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= latch_evt;
      if (latch_evt) sample_q <= fp_to_lin(word_mant, word_exp);
    end
  end

  assign sample = sample_q;
  assign valid  = valid_q;

  assert_silence_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && word_exp == '0) |=> (sample_q == '0 && valid_q));
  assert_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && (&word_exp)) |=> (sample_q[PRE_SHIFT-1:0] == '0 && sample_q[PRE_SHIFT]));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> ($stable(sample_q) && !valid_q));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/fpa_serial_rx.sv
module fpa_serial_rx
  import fpa_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        sel_left,
  input  logic        sel_right,
  output logic [15:0] left_sample,
  output logic        left_valid,
  output logic [15:0] right_sample,
  output logic        right_valid
);
  localparam int NCH  = 2;
  localparam int NIN  = NCH + 2;
  localparam int SEL0 = 2;

  logic [NIN-1:0]          lvl;
  logic [NIN-1:0]          prev_q;
  logic                    bit_rise;
  logic [NCH-1:0]          strobe_fall;
  logic [PAY_W-1:0]        payload;
  logic signed [OUT_W-1:0] lane_sample [NCH];
  logic [NCH-1:0]          lane_valid;

  fpa_rx_sync #(.W(NIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sel_right, sel_left, ser_data, ser_clk}),
    .sync_out (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign bit_rise = lvl[0] & ~prev_q[0];

  fpa_rx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (bit_rise),
    .bit_in   (lvl[1]),
    .payload  (payload)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign strobe_fall[c] = prev_q[SEL0+c] & ~lvl[SEL0+c];
    fpa_rx_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_fall (strobe_fall[c]),
      .payload     (payload),
      .sample      (lane_sample[c]),
      .valid       (lane_valid[c])
    );
  end

  assign left_sample  = lane_sample[0];
  assign right_sample = lane_sample[1];
  assign left_valid   = lane_valid[0];
  assign right_valid  = lane_valid[1];

  assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_fall) |=> $onehot0(lane_valid));
endmodule

// File: tb/fpa_serial_rx_tb_top.sv
module fpa_serial_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, sel_left = 1'b0, sel_right = 1'b0;
  logic [15:0] left_sample, right_sample;
  logic left_valid, right_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  fpa_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .sel_left(sel_left), .sel_right(sel_right),
    .left_sample(left_sample), .left_valid(left_valid),
    .right_sample(right_sample), .right_valid(right_valid)
  );

  // Independent reading of R3/R4/R5: integer floor division
  function automatic int expect_val(input int mant, input int e);
    int m, odd, x, d, q;
    if (e == 0) return 0;
    m = mant - 512;
    odd = 2 * m + 1;
    x = odd * 32;
    d = 1 << (7 - e);
    q = x / d;
    if (x < 0 && (x % d) != 0) q = q - 1;
    return q;
  endfunction

  // Reference model: pin history sampled each edge, events applied two edges later (R8)
  logic [3:0] hist[$];
  bit [15:0] mword;
  int exp_s[2];
  bit exp_v[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      mword = '0;
      exp_s[0] = 0; exp_s[1] = 0; exp_v[0] = 0; exp_v[1] = 0;
    end else begin
      hist.push_back({sel_right, sel_left, ser_data, ser_clk});
      exp_v[0] = 0; exp_v[1] = 0;
      if (hist.size() >= 4) begin
        for (int c = 0; c < 2; c++) begin
          if (hist[hist.size()-4][2+c] && !hist[hist.size()-3][2+c]) begin
            exp_s[c] = expect_val(int'(mword[15:6]), int'(mword[15:13] == 3'b0 ? 0 : 0) + int'(mword[15:13]));
            exp_s[c] = expect_val(int'(mword[12:3]), int'(mword[15:13]));
            exp_v[c] = 1;
          end
        end
        if (hist[hist.size()-3][0] && !hist[hist.size()-4][0])
          mword = {hist[hist.size()-3][1], mword[15:1]};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ($signed(left_sample) != exp_s[0] || left_valid != exp_v[0] ||
          $signed(right_sample) != exp_s[1] || right_valid != exp_v[1]) begin
        failures++;
        $display("FAIL R8 (%s) per-cycle: actual L=%0d/%0b R=%0d/%0b expected L=%0d/%0b R=%0d/%0b",
                 cur_req, $signed(left_sample), left_valid, $signed(right_sample), right_valid,
                 exp_s[0], exp_v[0], exp_s[1], exp_v[1]);
      end
    end
  end

  task automatic check_ch(input int c, input int expv, input string tag);
    int act;
    act = (c == 0) ? int'($signed(left_sample)) : int'($signed(right_sample));
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s ch%0d: actual %0d expected %0d", tag, c, act, expv);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Word layout (R2): bits 0..2 dc, 3..12 mantissa, 13..15 exponent; LSB first
  task automatic send_word(input int c, input int mant, input int e, input int dc);
    bit [15:0] w;
    w = {e[2:0], mant[9:0], dc[2:0]};
    @(negedge clk);
    if (c == 0) sel_left = 1; else sel_right = 1;
    for (int i = 0; i < 16; i++) begin
      ser_data = w[i];
      wait_neg(2);
      ser_clk = 1;
      wait_neg(3);
      ser_clk = 0;
      wait_neg(1);
    end
    wait_neg(2);
    if (c == 0) sel_left = 0; else sel_right = 0;
    wait_neg(8);
  endtask

  initial begin
    wait_neg(4);
    // R1: reset state
    checks++;
    if (left_sample != 0 || right_sample != 0 || left_valid || right_valid) begin
      failures++;
      $display("FAIL R1 reset: actual L=%0d R=%0d vl=%0b vr=%0b expected 0 0 0 0",
               left_sample, right_sample, left_valid, right_valid);
    end
    rst_n = 1;
    wait_neg(4);

    cur_req = "R2";
    send_word(0, 'h3FF, 7, 0);
    check_ch(0, 32736, "R4 max positive");
    check_ch(1, 0, "R7 right untouched");

    cur_req = "R3";
    send_word(1, 'h000, 7, 5);
    check_ch(1, -32736, "R3 max negative");
    check_ch(0, 32736, "R7 left held");

    send_word(0, 'h200, 6, 2);
    check_ch(0, 16, "R3 midpoint odd term");

    cur_req = "R4";
    send_word(0, 'h1FF, 2, 0);
    check_ch(0, -1, "R4 floor of -1/2^5");
    send_word(0, 'h155, 1, 7);
    check_ch(0, -171, "R4 floor at N=6");
    send_word(1, 'h2C7, 4, 1);
    check_ch(1, expect_val('h2C7, 4), "R4 mid exponent");

    cur_req = "R5";
    send_word(1, 'h3FF, 0, 0);
    check_ch(1, 0, "R5 reserved exponent silence");
    check_ch(0, -171, "R6 left not updated by right strobe");

    cur_req = "R9";
    send_word(0, 'h2AB, 5, 0);
    check_ch(0, expect_val('h2AB, 5), "R9 dc=000");
    send_word(0, 'h2AB, 5, 7);
    check_ch(0, expect_val('h2AB, 5), "R9 dc=111");

    cur_req = "R7";
    // Bit clock toggles with no strobe: outputs must hold
    for (int i = 0; i < 10; i++) begin
      ser_data = i[0]; wait_neg(2); ser_clk = 1; wait_neg(2); ser_clk = 0; wait_neg(1);
    end
    wait_neg(4);
    check_ch(0, expect_val('h2AB, 5), "R7 hold under bit clock");
    check_ch(1, 0, "R7 hold right");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < 100000; t++) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule